// File: doc/BRIEF.md
# Banked Operand Buffer with Transposing Writeback

This block holds the operands and results of a square systolic array of `LANES` × `LANES` cells. It has six operand buffers, numbered 0 to 5: weight, bias, X, Q, K and V. Each buffer is built from `LANES` independent 8-bit RAM banks, so one address returns a whole row of `LANES` elements, one element per bank. An idle-time load port fills the buffers one row at a time. A single start pulse launches an operation. The operation names two distinct buffers: one feeds the left edge of the array and one feeds the top edge. It also names the buffer that receives the drained results.

The fetch side streams both edges together as one valid/ready stream. Lane i is delayed by i beats, which gives the diagonal wavefront the array needs. An operation of `len` rows therefore produces `len + LANES - 1` beats. The drained result arrives as a second valid/ready stream of exactly `LANES` row vectors. These are written to consecutive addresses, either rising from the base or falling from base + `LANES` - 1. Transposition needs no separate unit: when results leave the array column by column and are written in falling order, the stored matrix is the transpose.

Back-pressure rules:
- `fe_valid` is a registered output. Once it is raised, it stays high with `fe_left` and `fe_top` unchanged until a cycle in which `fe_ready` is high.
- `wb_ready` does not depend on `wb_valid`.
- A beat moves on any rising edge where valid and ready are both high.
- Each bank is single-ported. When a result write and a fetch read target the same buffer in the same cycle, the write is served and the fetch waits for a later cycle.

Top module: `opbuf_xpose`

## Requirements
- R1: After reset, `busy`, `fe_valid` and `wb_ready` are 0 and `ld_ready` is 1.
- R2: `ld_ready` equals the inverse of `busy`. An accepted load with `ld_sel` in 0..5 writes byte i of `ld_row` (bits 8i+7..8i) into bank i of that buffer at `ld_addr`. A load with `ld_sel` of 6 or 7 writes nothing.
- R3: An operation of length `len` emits exactly `len + LANES - 1` fetch beats. In beat t, lane i of `fe_left` equals element i of left-buffer row `left_base + t - i` (modulo depth) when 0 ≤ t - i < `len`, and 0 otherwise. `fe_top` follows the same rule with the top buffer and its base.
- R4: While `fe_valid` is 1 and `fe_ready` is 0, on the next cycle `fe_valid` stays 1 and `fe_left`/`fe_top` are unchanged. No beat is lost or repeated.
- R5: With `op_wb_desc` = 0, the k-th accepted result vector (k from 0) is written to the result buffer at `op_wb_base + k`, lane i into bank i.
- R6: With `op_wb_desc` = 1, the k-th accepted result vector is written at `op_wb_base + LANES - 1 - k`.
- R7: If the vectors arrive as the columns of a matrix M, last column first, and are written in falling order, then row j of the result buffer holds column j of M, which is the transpose of M.
- R8: A result write into a buffer that is currently being fetched takes effect in the same cycle, and the fetch read waits for a later cycle. The fetched stream still equals the contents that were in place before the operation, at addresses the write does not touch.
- R9: `busy` rises the cycle after an accepted start. It falls only after the last fetch beat and the last result beat have both been accepted. A start while `busy` is high is ignored.
- R10: `wb_ready` is 0 whenever `busy` is 0. Exactly `LANES` result beats are accepted per operation, after which `wb_ready` stays 0.
- R11: A start is ignored (`busy` stays 0) when the left and top selections are equal, when any selection is 6 or 7, or when `op_len` is 0 or greater than `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load row valid |
| ld_ready | output | 1 | Load row accepted (idle only) |
| ld_sel | input | 3 | Target buffer code, 0 to 5 |
| ld_addr | input | AW | Row address |
| ld_row | input | LANES*8 | Row data, lane i in bits 8i+7..8i |
| start | input | 1 | Launch an operation (pulse) |
| op_left_sel | input | 3 | Buffer that feeds the left edge |
| op_left_base | input | AW | First left row address |
| op_top_sel | input | 3 | Buffer that feeds the top edge |
| op_top_base | input | AW | First top row address |
| op_len | input | AW+1 | Rows fetched per edge, 1 to DEPTH |
| op_wb_sel | input | 3 | Buffer that receives results |
| op_wb_base | input | AW | Lowest result address |
| op_wb_desc | input | 1 | 1: falling write order |
| busy | output | 1 | Operation in progress |
| fe_valid | output | 1 | Fetch beat valid |
| fe_ready | input | 1 | Array accepts fetch beat |
| fe_left | output | LANES*8 | Skewed left-edge lanes |
| fe_top | output | LANES*8 | Skewed top-edge lanes |
| wb_valid | input | 1 | Result vector valid |
| wb_ready | output | 1 | Result vector accepted |
| wb_row | input | LANES*8 | Result vector, lane i in bits 8i+7..8i |

## Verification
Several fetch patterns exercise the main function:
- A length longer than the array with the consumer always ready, which exposes skew and flush-length errors.
- A consumer that stalls every third cycle, which separates a correct hold from a dropped or repeated beat.
- A base near the end of a buffer, which checks address arithmetic.

Result writes are checked by fetching them back in later operations, once in rising order and once in falling order. A column-wise drain written in falling order is then compared against the transpose of a known matrix. One operation writes into the buffer it is also fetching, which forces fetch stalls and distinguishes write-priority arbitration from a corrupted or shifted stream.

// File: rtl/opbuf_pkg.sv
package opbuf_pkg;
  localparam int NUM_BUF = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    BUF_WGT  = 3'd0,
    BUF_BIAS = 3'd1,
    BUF_X    = 3'd2,
    BUF_Q    = 3'd3,
    BUF_K    = 3'd4,
    BUF_V    = 3'd5
  } buf_id_e;

  function automatic logic sel_legal(input logic [SEL_W-1:0] s);
    return s < SEL_W'(NUM_BUF);
  endfunction
endpackage

// File: rtl/opbuf_bank.sv
module opbuf_bank #(
  parameter int EW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read data is held until the next read of this bank
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/opbuf_store.sv
module opbuf_store
  import opbuf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  localparam int RW   = LANES * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]    wr_addr,
  input  logic [RW-1:0]    wr_row,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel_a,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [SEL_W-1:0] rd_sel_b,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [RW-1:0]    rd_row_a,
  output logic [RW-1:0]    rd_row_b
);
  logic [RW-1:0] q [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic          we_b, hit_a, hit_b, re_b;
    logic [AW-1:0] addr_b;

    assign we_b   = wr_en && (wr_sel == SEL_W'(b));
    assign hit_a  = rd_en && (rd_sel_a == SEL_W'(b));
    assign hit_b  = rd_en && (rd_sel_b == SEL_W'(b));
    assign re_b   = (hit_a || hit_b) && !we_b;   // write wins the bank
    assign addr_b = we_b ? wr_addr : (hit_a ? rd_addr_a : rd_addr_b);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      opbuf_bank #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_b),
        .re    (re_b),
        .addr  (addr_b),
        .wdata (wr_row[l*EW +: EW]),
        .rdata (q[b][l*EW +: EW])
      );
    end

    // each buffer serves at most one edge of the array
    assert_one_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_a && hit_b));
  end

  always_comb begin
    rd_row_a = '0;
    rd_row_b = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (rd_sel_a == SEL_W'(b)) rd_row_a = q[b];
      if (rd_sel_b == SEL_W'(b)) rd_row_b = q[b];
    end
  end
endmodule

// File: rtl/opbuf_skew.sv
module opbuf_skew #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  localparam int RW   = LANES * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [RW-1:0] row_in,
  output logic [RW-1:0] row_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_direct
      logic [EW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (shift)    q <= row_in[EW-1:0];
      end
      assign row_out[EW-1:0] = q;
    end else begin : g_delay
      logic [EW-1:0] dl [i];
      logic [EW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          for (int k = 0; k < i; k++) dl[k] <= '0;
          q <= '0;
        end else if (shift) begin
          dl[0] <= row_in[i*EW +: EW];
          for (int k = 1; k < i; k++) dl[k] <= dl[k-1];
          q <= dl[i-1];
        end
      end
      assign row_out[i*EW +: EW] = q;
    end
  end
endmodule

// File: rtl/opbuf_fetch.sv
module opbuf_fetch #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int FW   = $clog2(LANES) + 1,
  localparam int RW   = LANES * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] left_base,
  input  logic [AW-1:0] top_base,
  input  logic [LW-1:0] len,
  input  logic          conflict,
  output logic          rd_en,
  output logic          stall,
  output logic [AW-1:0] rd_addr_l,
  output logic [AW-1:0] rd_addr_t,
  input  logic [RW-1:0] rd_row_l,
  input  logic [RW-1:0] rd_row_t,
  output logic          fe_valid,
  input  logic          fe_ready,
  output logic [RW-1:0] fe_left,
  output logic [RW-1:0] fe_top,
  output logic          done
);
  logic          active, pend;
  logic [LW-1:0] iss_cnt;
  logic [FW-1:0] flush_rem;
  logic          issuing, slot, flushing, shift, want, finish;
  logic [RW-1:0] row_l, row_t;

  assign issuing  = active && (iss_cnt < len);
  assign slot     = !fe_valid || fe_ready;
  assign flushing = active && !issuing && !pend && (flush_rem != '0);
  assign shift    = (pend || flushing) && slot;
  assign want     = issuing && (!pend || shift);
  assign rd_en    = want && !conflict;
  assign stall    = want && conflict;
  assign finish   = active && !issuing && !pend && (flush_rem == '0) && slot;

  assign rd_addr_l = left_base + AW'(iss_cnt);
  assign rd_addr_t = top_base + AW'(iss_cnt);
  assign row_l     = pend ? rd_row_l : '0;
  assign row_t     = pend ? rd_row_t : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; pend <= 1'b0; iss_cnt <= '0;
      flush_rem <= '0; fe_valid <= 1'b0; done <= 1'b0;
    end else if (go) begin
      active <= 1'b1; pend <= 1'b0; iss_cnt <= '0;
      flush_rem <= FW'(LANES - 1); fe_valid <= 1'b0; done <= 1'b0;
    end else begin
      if (rd_en) iss_cnt <= iss_cnt + 1'b1;
      if (rd_en)      pend <= 1'b1;
      else if (shift) pend <= 1'b0;
      if (flushing && slot) flush_rem <= flush_rem - 1'b1;
      if (shift)         fe_valid <= 1'b1;
      else if (fe_ready) fe_valid <= 1'b0;
      if (finish) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  opbuf_skew #(.LANES(LANES), .EW(EW)) u_skew_l (
    .clk(clk), .rst_n(rst_n), .clr(go), .shift(shift), .row_in(row_l), .row_out(fe_left)
  );
  opbuf_skew #(.LANES(LANES), .EW(EW)) u_skew_t (
    .clk(clk), .rst_n(rst_n), .clr(go), .shift(shift), .row_in(row_t), .row_out(fe_top)
  );

  assert_hold_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && !fe_ready && !go) |=> (fe_valid && $stable(fe_left) && $stable(fe_top)));
endmodule

// File: rtl/opbuf_wb.sv
module opbuf_wb #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic          desc,
  input  logic          wb_valid,
  output logic          wb_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done
);
  logic          active;
  logic [CW-1:0] cnt;

  assign wb_ready = active;
  assign wr_en    = wb_valid && active;
  assign wr_addr  = desc ? (base + AW'(LANES - 1) - AW'(cnt)) : (base + AW'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; done <= 1'b0;
    end else if (go) begin
      active <= 1'b1; cnt <= '0; done <= 1'b0;
    end else if (wr_en) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LANES - 1)) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(go)) |->
      (wr_addr == (desc ? $past(wr_addr) - 1'b1 : $past(wr_addr) + 1'b1)));
endmodule

// File: rtl/opbuf_xpose.sv
module opbuf_xpose
  import opbuf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int RW   = LANES * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [AW-1:0]    ld_addr,
  input  logic [RW-1:0]    ld_row,
  input  logic             start,
  input  logic [SEL_W-1:0] op_left_sel,
  input  logic [AW-1:0]    op_left_base,
  input  logic [SEL_W-1:0] op_top_sel,
  input  logic [AW-1:0]    op_top_base,
  input  logic [LW-1:0]    op_len,
  input  logic [SEL_W-1:0] op_wb_sel,
  input  logic [AW-1:0]    op_wb_base,
  input  logic             op_wb_desc,
  output logic             busy,
  output logic             fe_valid,
  input  logic             fe_ready,
  output logic [RW-1:0]    fe_left,
  output logic [RW-1:0]    fe_top,
  input  logic             wb_valid,
  output logic             wb_ready,
  input  logic [RW-1:0]    wb_row
);
  logic             go, ld_fire;
  logic [SEL_W-1:0] left_q, top_q, wbs_q;
  logic [AW-1:0]    left_base_q, top_base_q, wb_base_q;
  logic [LW-1:0]    len_q;
  logic             desc_q;

  logic             rd_en, stall, conflict, fe_done;
  logic [AW-1:0]    rd_addr_l, rd_addr_t;
  logic [RW-1:0]    rd_row_l, rd_row_t;
  logic             wb_wr, wb_done;
  logic [AW-1:0]    wb_addr;

  logic             st_wr;
  logic [SEL_W-1:0] st_sel;
  logic [AW-1:0]    st_addr;
  logic [RW-1:0]    st_row;

  assign go = start && !busy && sel_legal(op_left_sel) && sel_legal(op_top_sel) &&
              sel_legal(op_wb_sel) && (op_left_sel != op_top_sel) &&
              (op_len != '0) && (op_len <= LW'(DEPTH));

  assign ld_ready = !busy;
  assign ld_fire  = ld_valid && !busy && sel_legal(ld_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left_q <= '0; top_q <= 3'd1; wbs_q <= '0;
      left_base_q <= '0; top_base_q <= '0; wb_base_q <= '0;
      len_q <= '0; desc_q <= 1'b0;
    end else if (go) begin
      busy        <= 1'b1;
      left_q      <= op_left_sel;
      top_q       <= op_top_sel;
      wbs_q       <= op_wb_sel;
      left_base_q <= op_left_base;
      top_base_q  <= op_top_base;
      wb_base_q   <= op_wb_base;
      len_q       <= op_len;
      desc_q      <= op_wb_desc;
    end else if (busy && fe_done && wb_done) begin
      busy <= 1'b0;
    end
  end

  // result writes take the bank; a fetch read of the same buffer waits
  assign conflict = wb_wr && ((wbs_q == left_q) || (wbs_q == top_q));

  assign st_wr   = busy ? wb_wr     : ld_fire;
  assign st_sel  = busy ? wbs_q     : ld_sel;
  assign st_addr = busy ? wb_addr   : ld_addr;
  assign st_row  = busy ? wb_row    : ld_row;

  opbuf_store #(.LANES(LANES), .EW(EW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_wr),
    .wr_sel    (st_sel),
    .wr_addr   (st_addr),
    .wr_row    (st_row),
    .rd_en     (rd_en),
    .rd_sel_a  (left_q),
    .rd_addr_a (rd_addr_l),
    .rd_sel_b  (top_q),
    .rd_addr_b (rd_addr_t),
    .rd_row_a  (rd_row_l),
    .rd_row_b  (rd_row_t)
  );

  opbuf_fetch #(.LANES(LANES), .EW(EW), .DEPTH(DEPTH), .AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .left_base (left_base_q),
    .top_base  (top_base_q),
    .len       (len_q),
    .conflict  (conflict),
    .rd_en     (rd_en),
    .stall     (stall),
    .rd_addr_l (rd_addr_l),
    .rd_addr_t (rd_addr_t),
    .rd_row_l  (rd_row_l),
    .rd_row_t  (rd_row_t),
    .fe_valid  (fe_valid),
    .fe_ready  (fe_ready),
    .fe_left   (fe_left),
    .fe_top    (fe_top),
    .done      (fe_done)
  );

  opbuf_wb #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .base     (wb_base_q),
    .desc     (desc_q),
    .wb_valid (wb_valid),
    .wb_ready (wb_ready),
    .wr_en    (wb_wr),
    .wr_addr  (wb_addr),
    .done     (wb_done)
  );

  assert_write_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !(wb_wr && ((wbs_q == left_q) || (wbs_q == top_q))));
  assert_stall_on_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> wb_wr);
  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wb_ready);
  assert_distinct_edges_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != top_q));
endmodule

// File: tb/opbuf_xpose_tb.sv
module opbuf_xpose_tb;
  localparam int N  = 4;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int LW = 5;
  localparam int RW = N * 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_valid, ld_ready;
  logic [2:0] ld_sel;
  logic [AW-1:0] ld_addr;
  logic [RW-1:0] ld_row;
  logic start;
  logic [2:0] op_left_sel, op_top_sel, op_wb_sel;
  logic [AW-1:0] op_left_base, op_top_base, op_wb_base;
  logic [LW-1:0] op_len;
  logic op_wb_desc, busy;
  logic fe_valid, fe_ready;
  logic [RW-1:0] fe_left, fe_top;
  logic wb_valid, wb_ready;
  logic [RW-1:0] wb_row;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [6][D][N];

  always #5 clk = ~clk;

  opbuf_xpose #(.LANES(N), .EW(8), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_row(ld_row),
    .start(start), .op_left_sel(op_left_sel), .op_left_base(op_left_base),
    .op_top_sel(op_top_sel), .op_top_base(op_top_base), .op_len(op_len),
    .op_wb_sel(op_wb_sel), .op_wb_base(op_wb_base), .op_wb_desc(op_wb_desc), .busy(busy),
    .fe_valid(fe_valid), .fe_ready(fe_ready), .fe_left(fe_left), .fe_top(fe_top),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_row(wb_row)
  );

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int b, int a, int l);
    return 8'(b * 37 + a * 11 + l * 3 + 1);
  endfunction

  // matrix whose transpose is stored by the transposing scenario
  function automatic logic [7:0] mat(int r, int c);
    return 8'(16 * r + c + 5);
  endfunction

  function automatic logic [RW-1:0] result_vec(int mode, int k);
    logic [RW-1:0] v;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: v[i*8 +: 8] = 8'(100 + 10 * k + i);
        1: v[i*8 +: 8] = 8'(200 + 7 * k + i);
        2: v[i*8 +: 8] = mat(i, N - 1 - k);   // columns, last one first
        default: v[i*8 +: 8] = 8'(50 + k + i);
      endcase
    end
    return v;
  endfunction

  function automatic logic [RW-1:0] exp_beat(int sel, int base, int len, int t);
    logic [RW-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      int s = t - i;
      if (s >= 0 && s < len) v[i*8 +: 8] = model[sel][(base + s) % D][i];
    end
    return v;
  endfunction

  task automatic load_row(input int sel, input int addr, input logic [RW-1:0] row);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 3'(sel); ld_addr = AW'(addr); ld_row = row;
    @(negedge clk);
    ld_valid = 1'b0;
    if (sel < 6) for (int i = 0; i < N; i++) model[sel][addr][i] = row[i*8 +: 8];
  endtask

  task automatic collect(input int ls, input int lb, input int ts, input int tb, input int len,
                         input int rmode, input string ltag, input string ttag);
    int t = 0;
    int cyc = 0;
    bit held = 0;
    logic [RW-1:0] hl, ht;
    while (t < len + N - 1 && cyc < 400) begin
      bit rdy;
      @(negedge clk);
      rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      fe_ready = rdy;
      #1;
      if (held) begin
        check("R4 hold valid", RW'(fe_valid), RW'(1));
        check("R4 hold left", fe_left, hl);
        check("R4 hold top", fe_top, ht);
      end
      held = fe_valid && !rdy;
      hl = fe_left; ht = fe_top;
      if (fe_valid && rdy) begin
        check(ltag, fe_left, exp_beat(ls, lb, len, t));
        check(ttag, fe_top, exp_beat(ts, tb, len, t));
        t++;
      end
      cyc++;
    end
    check("R3 beat count", RW'(t), RW'(len + N - 1));
    @(negedge clk);
    fe_ready = 1'b1;
  endtask

  task automatic drive_wb(input int ws, input int wbase, input int desc, input int mode);
    int k = 0;
    int cyc = 0;
    while (k < N && cyc < 400) begin
      @(negedge clk);
      wb_valid = 1'b1;
      wb_row = result_vec(mode, k);
      #1;
      if (wb_ready) begin
        int a = desc ? (wbase + N - 1 - k) % D : (wbase + k) % D;
        for (int i = 0; i < N; i++) model[ws][a][i] = wb_row[i*8 +: 8];
        k++;
      end
      cyc++;
    end
    @(negedge clk);
    #1;
    check("R10 ready after last result", RW'(wb_ready), RW'(0));
    wb_valid = 1'b0;
  endtask

  task automatic run_op(input int ls, input int lb, input int ts, input int tb, input int len,
                        input int ws, input int wbase, input int desc, input int wmode,
                        input int rmode, input string ltag, input string ttag, input bit poke);
    @(negedge clk);
    start = 1'b1;
    op_left_sel = 3'(ls); op_left_base = AW'(lb);
    op_top_sel = 3'(ts); op_top_base = AW'(tb);
    op_len = LW'(len); op_wb_sel = 3'(ws); op_wb_base = AW'(wbase); op_wb_desc = desc[0];
    @(negedge clk);
    start = 1'b0;
    check("R9 busy after start", RW'(busy), RW'(1));
    check("R2 load blocked while busy", RW'(ld_ready), RW'(0));
    if (poke) begin
      // a second start while busy must be ignored
      start = 1'b1; op_left_sel = 3'd5; op_top_sel = 3'd1; op_len = LW'(2);
      @(negedge clk);
      start = 1'b0;
    end
    fork
      collect(ls, lb, ts, tb, len, rmode, ltag, ttag);
      drive_wb(ws, wbase, desc, wmode);
    join
    for (int c = 0; c < 20 && busy; c++) @(negedge clk);
    check("R9 busy falls", RW'(busy), RW'(0));
    check("R3 no extra beat", RW'(fe_valid), RW'(0));
  endtask

  task automatic try_bad_start(input int ls, input int ts, input int ws, input int len, input string tag);
    @(negedge clk);
    start = 1'b1; op_left_sel = 3'(ls); op_top_sel = 3'(ts); op_wb_sel = 3'(ws); op_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    check(tag, RW'(busy), RW'(0));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; ld_sel = 0; ld_addr = 0; ld_row = 0;
    start = 0; op_left_sel = 0; op_top_sel = 0; op_wb_sel = 0;
    op_left_base = 0; op_top_base = 0; op_wb_base = 0; op_len = 0; op_wb_desc = 0;
    fe_ready = 1'b1; wb_valid = 0; wb_row = 0;
    for (int b = 0; b < 6; b++) for (int a = 0; a < D; a++) for (int i = 0; i < N; i++)
      model[b][a][i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", RW'(busy), RW'(0));
    check("R1 fe_valid", RW'(fe_valid), RW'(0));
    check("R1 wb_ready", RW'(wb_ready), RW'(0));
    check("R1 ld_ready", RW'(ld_ready), RW'(1));

    // fill weight, X and K; then an illegal-code load that must write nothing
    for (int b = 0; b < 6; b++) begin
      if (b == 0 || b == 2 || b == 4) begin
        for (int a = 0; a < D; a++) begin
          logic [RW-1:0] r;
          for (int i = 0; i < N; i++) r[i*8 +: 8] = pat(b, a, i);
          load_row(b, a, r);
        end
      end
    end
    load_row(7, 2, {RW{1'b1}});
    load_row(6, 3, {RW{1'b1}});

    // long fetch, free-running consumer, rising writeback into Q, start poked while busy
    run_op(0, 0, 2, 2, 6, 3, 0, 0, 0, 0, "R3 left lanes", "R2 top lanes after ignored load", 1);
    // Q read back (rising order); result written into K while K is fetched; stalling consumer
    run_op(3, 0, 4, 0, N, 4, 8, 1, 1, 1, "R5 rising writeback", "R8 fetch under write priority", 0);
    // K read back (falling order); columns written falling into V; top base near the end
    run_op(4, 8, 0, 10, 5, 5, 0, 1, 2, 1, "R6 falling writeback", "R3 top lanes", 0);
    // V must now hold the transpose of the matrix
    for (int j = 0; j < N; j++) begin
      logic [RW-1:0] tr;
      for (int i = 0; i < N; i++) tr[i*8 +: 8] = mat(i, j);
      for (int i = 0; i < N; i++) model[5][j][i] = tr[i*8 +: 8];
    end
    run_op(5, 0, 2, 12, N, 1, 0, 0, 3, 0, "R7 transposed rows", "R3 top lanes", 0);

    try_bad_start(2, 2, 3, 4, "R11 equal edges ignored");
    try_bad_start(6, 2, 3, 4, "R11 illegal select ignored");
    try_bad_start(0, 2, 3, 0, "R11 zero length ignored");
    try_bad_start(0, 2, 3, D + 1, "R11 overlong ignored");
    check("R10 idle no result ready", RW'(wb_ready), RW'(0));

    summary();
  end
endmodule